// File: doc/BRIEF.md
# Bit-Slice Ripple Arithmetic Logic Unit

This block is a purely combinational integer ALU made from a row of identical one-bit slices. Every slice holds a two-input AND, a two-input OR, a full adder with a selectable inverter in front of its second operand, and a four-way result selector. The carry leaving each slice enters the next one, and all slices share the same control lines. The only cross-chain link is the signed less-than result, which is formed in the top slice and routed back to bit 0.

A four-bit operation code selects one of five operations: bitwise AND, bitwise OR, addition, subtraction, or signed set-on-less-than. Subtraction and the comparison reuse the adder. They invert every B bit and force a carry of 1 into the lowest slice. Beside the result, the unit reports a zero flag and the carry leaving the top slice. The operand width is a parameter and defaults to 32 bits. Shifts, multiplication and division are handled by other units.

Top module: `bitslice_alu`

## Requirements
- R1: Each slice adds as a full adder: its sum bit is the XOR of operand A, the effective B bit and the incoming carry, and its carry out is 1 when at least two of those three are 1. Carries ripple from bit i to bit i+1.
- R2: Code 4'b0000 returns the bitwise AND of A and B, and code 4'b0001 returns the bitwise OR.
- R3: Code 4'b0010 returns the low WIDTH bits of A+B, and carry_o is bit WIDTH of that sum.
- R4: Code 4'b0110 returns A + ~B + 1, the low WIDTH bits of A−B. carry_o is the carry out of that sum, which is 1 exactly when A ≥ B as unsigned values.
- R5: Code 4'b0111 returns 1 in bit 0 when A < B as two's-complement values and 0 otherwise. All higher bits are 0. The comparison stays correct when A−B overflows, for example A = 0x80000000 and B = 1.
- R6: zero_o is 1 exactly when every result bit is 0.
- R7: Every other code returns a result of 0, so zero_o is 1.
- R8: For AND, OR and the unused codes, carry_o is the carry out of A+B. For codes 0110 and 0111 it is the carry out of A + ~B + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry leaving the top slice |

## Verification
The bench builds two copies of the block.

The default 32-bit copy covers the main tests:
- sign-boundary cases such as 0x80000000 minus 1;
- equal operands under subtraction;
- the all-ones carry chain;
- random operands for every code.

An 8-bit copy checks the same rules with random operands. Because its ranges are small, signed overflow, the unsigned borrow and the wrap of the full carry chain occur often. It also confirms that the slice chain, the sign-slice feedback and the zero detector all follow the width parameter.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OPC_AND = 4'b0000,
      OPC_OR  = 4'b0001,
      OPC_ADD = 4'b0010,
      OPC_SUB = 4'b0110,
      OPC_SLT = 4'b0111
   } opcode_e;

   typedef enum logic [1:0] {
      PICK_AND  = 2'd0,
      PICK_OR   = 2'd1,
      PICK_SUM  = 2'd2,
      PICK_LESS = 2'd3
   } pick_e;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output pick_e           pick_o,
   output logic            binv_o,
   output logic            cin0_o,
   output logic            valid_o
);

   always_comb begin
      pick_o  = PICK_SUM;
      binv_o  = 1'b0;
      valid_o = 1'b1;
      case (op_i)
         OPC_AND: pick_o = PICK_AND;
         OPC_OR:  pick_o = PICK_OR;
         OPC_ADD: pick_o = PICK_SUM;
         OPC_SUB: begin
            pick_o = PICK_SUM;
            binv_o = 1'b1;
         end
         OPC_SLT: begin
            pick_o = PICK_LESS;
            binv_o = 1'b1;
         end
         default: valid_o = 1'b0;
      endcase
   end

   // the borrow-free subtract needs a carry of 1 whenever B is inverted
   assign cin0_o = binv_o;

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_pkg::*;
#(
   parameter bit IS_MSB = 1'b0
)(
   input  logic  a_i,
   input  logic  b_i,
   input  logic  cin_i,
   input  logic  binv_i,
   input  logic  less_i,
   input  pick_e pick_i,
   output logic  res_o,
   output logic  cout_o,
   output logic  set_o
);

   logic b_eff;
   logic sum;

   assign b_eff  = b_i ^ binv_i;
   assign sum    = a_i ^ b_eff ^ cin_i;
   assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

   always_comb begin
      case (pick_i)
         PICK_AND:  res_o = a_i & b_i;
         PICK_OR:   res_o = a_i | b_i;
         PICK_SUM:  res_o = sum;
         default:   res_o = less_i;
      endcase
   end

   generate
      if (IS_MSB) begin : g_sign
         logic ovf;
         // signed overflow: carry into the top bit differs from carry out
         assign ovf   = cin_i ^ cout_o;
         assign set_o = sum ^ ovf;
      end else begin : g_plain
         assign set_o = 1'b0;
      end
   endgenerate

   // R1: when both adder operands agree, the carry must follow them
   always_comb begin
      if (a_i == b_eff)
         p_slice_carry_r1: assert (cout_o == a_i)
            else $error("slice carry disagrees with operands");
   end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int WIDTH = 32
)(
   input  logic [WIDTH-1:0] val_i,
   output logic             zero_o
);

   initial begin
      if (WIDTH < 1) $error("alu_zero_detect: WIDTH must be positive");
   end

   assign zero_o = ~|val_i;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
)(
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [3:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             carry_o
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitslice_alu: WIDTH must be at least 2");
      end
   endgenerate

   pick_e            pick;
   logic             binv;
   logic             cin0;
   logic             valid;
   logic [WIDTH:0]   chain;
   logic [WIDTH-1:0] slice_res;
   logic             set_msb;

   alu_op_decode u_dec (
      .op_i    (op_i),
      .pick_o  (pick),
      .binv_o  (binv),
      .cin0_o  (cin0),
      .valid_o (valid)
   );

   assign chain[0] = cin0;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         logic less_in;
         if (i == 0) begin : g_lsb_less
            assign less_in = set_msb;
         end else begin : g_zero_less
            assign less_in = 1'b0;
         end

         if (i == MSB) begin : g_top
            alu_bit_slice #(.IS_MSB(1'b1)) u_bit (
               .a_i    (opa_i[i]),
               .b_i    (opb_i[i]),
               .cin_i  (chain[i]),
               .binv_i (binv),
               .less_i (less_in),
               .pick_i (pick),
               .res_o  (slice_res[i]),
               .cout_o (chain[i+1]),
               .set_o  (set_msb)
            );
         end else begin : g_mid
            logic unused_set;
            alu_bit_slice #(.IS_MSB(1'b0)) u_bit (
               .a_i    (opa_i[i]),
               .b_i    (opb_i[i]),
               .cin_i  (chain[i]),
               .binv_i (binv),
               .less_i (less_in),
               .pick_i (pick),
               .res_o  (slice_res[i]),
               .cout_o (chain[i+1]),
               .set_o  (unused_set)
            );
         end
      end
   endgenerate

   assign result_o = valid ? slice_res : '0;
   assign carry_o  = chain[WIDTH];

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .val_i  (result_o),
      .zero_o (zero_o)
   );

   // checks against independent arithmetic on the ports
   always_comb begin
      if (op_i == OPC_AND)
         p_and_bits_r2: assert (result_o == (opa_i & opb_i))
            else $error("AND result mismatch");
      if (op_i == OPC_ADD)
         p_add_sum_r3: assert ({carry_o, result_o} == ({1'b0, opa_i} + {1'b0, opb_i}))
            else $error("ADD result mismatch");
      if (op_i == OPC_SUB && opa_i == opb_i)
         p_sub_equal_r4: assert (zero_o && carry_o)
            else $error("equal operands did not subtract to zero");
      if (op_i == OPC_SLT)
         p_slt_upper_r5: assert (result_o[WIDTH-1:1] == '0)
            else $error("SLT upper bits not clear");
      if (!(op_i inside {OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_SLT}))
         p_unused_zero_r7: assert (zero_o && result_o == '0)
            else $error("unused code produced a value");
   end

endmodule

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit timed_out = 1'b0;

   logic [31:0] a32, b32;
   logic [3:0]  op32;
   logic [31:0] r32;
   logic        z32, c32;

   logic [7:0]  a8, b8;
   logic [3:0]  op8;
   logic [7:0]  r8;
   logic        z8, c8;

   bitslice_alu #(.WIDTH(32)) u0 (
      .opa_i(a32), .opb_i(b32), .op_i(op32),
      .result_o(r32), .zero_o(z32), .carry_o(c32)
   );

   bitslice_alu #(.WIDTH(8)) u1 (
      .opa_i(a8), .opb_i(b8), .op_i(op8),
      .result_o(r8), .zero_o(z8), .carry_o(c8)
   );

   // model built from the requirements, width w up to 32
   function automatic void model(input int w, input logic [31:0] a, input logic [31:0] b,
                                 input logic [3:0] op, output logic [31:0] r,
                                 output logic c);
      logic [31:0] mask;
      logic [32:0] s_add, s_sub;
      logic        sa, sb, lt;
      mask  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      a     = a & mask;
      b     = b & mask;
      s_add = {1'b0, a} + {1'b0, b};
      s_sub = {1'b0, a} + {1'b0, (~b) & mask} + 33'd1;
      sa    = a[w-1];
      sb    = b[w-1];
      lt    = (sa != sb) ? sa : (a < b);
      case (op)
         4'b0000: r = a & b;
         4'b0001: r = a | b;
         4'b0010: r = s_add[31:0] & mask;
         4'b0110: r = s_sub[31:0] & mask;
         4'b0111: r = {31'd0, lt};
         default: r = 32'd0;
      endcase
      c = (op == 4'b0110 || op == 4'b0111) ? s_sub[w] : s_add[w];
   endfunction

   task automatic chk32(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] op);
      logic [31:0] er;
      logic        ec;
      @(posedge clk);
      a32 = a; b32 = b; op32 = op;
      #5;
      model(32, a, b, op, er, ec);
      n_checks++;
      if (r32 !== er || c32 !== ec || z32 !== (er == 32'd0)) begin
         n_fail++;
         $display("FAIL %s op=%b a=%h b=%h: got r=%h c=%b z=%b, expected r=%h c=%b z=%b",
                  req, op, a, b, r32, c32, z32, er, ec, (er == 32'd0));
      end
   endtask

   task automatic chk8(input string req, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] op);
      logic [31:0] er;
      logic        ec;
      @(posedge clk);
      a8 = a; b8 = b; op8 = op;
      #5;
      model(8, {24'd0, a}, {24'd0, b}, op, er, ec);
      n_checks++;
      if (r8 !== er[7:0] || c8 !== ec || z8 !== (er == 32'd0)) begin
         n_fail++;
         $display("FAIL %s w8 op=%b a=%h b=%h: got r=%h c=%b z=%b, expected r=%h c=%b z=%b",
                  req, op, a, b, r8, c8, z8, er[7:0], ec, (er == 32'd0));
      end
   endtask

   task automatic t_idle;
      chk32("R6 idle", 32'd0, 32'd0, 4'b0000);
   endtask

   task automatic t_logic;
      chk32("R2 and", 32'h0000_002C, 32'h0000_000A, 4'b0000);
      chk32("R2 or",  32'h0000_002C, 32'h0000_000A, 4'b0001);
      chk32("R8 and carry", 32'hFFFF_FFFF, 32'h0000_0001, 4'b0000);
      chk32("R8 or carry",  32'h8000_0000, 32'h8000_0000, 4'b0001);
   endtask

   task automatic t_add;
      chk32("R3 add", 32'd156, 32'd99, 4'b0010);
      chk32("R1 R3 full ripple", 32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
      chk32("R1 R3 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010);
      chk32("R3 overflow", 32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
   endtask

   task automatic t_sub;
      chk32("R4 minimum minus one", 32'h8000_0000, 32'h0000_0001, 4'b0110);
      chk32("R4 R6 equal", 32'h1234_5678, 32'h1234_5678, 4'b0110);
      chk32("R4 borrow", 32'd3, 32'd5, 4'b0110);
      chk32("R4 zero minus zero", 32'd0, 32'd0, 4'b0110);
   endtask

   task automatic t_slt;
      chk32("R5 overflow case", 32'h8000_0000, 32'h0000_0001, 4'b0111);
      chk32("R5 reverse overflow", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
      chk32("R5 equal", 32'h0000_0042, 32'h0000_0042, 4'b0111);
      chk32("R5 neg vs neg", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'b0111);
      chk32("R5 pos greater", 32'd9, 32'd2, 4'b0111);
   endtask

   task automatic t_unused;
      chk32("R7 code 0011", 32'hDEAD_BEEF, 32'h1234_5678, 4'b0011);
      chk32("R7 code 1111", 32'hFFFF_FFFF, 32'h0000_0001, 4'b1111);
      chk32("R7 R8 code 1000", 32'h8000_0000, 32'h8000_0000, 4'b1000);
   endtask

   task automatic t_random32;
      logic [3:0] ops [5] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111};
      for (int k = 0; k < 400; k++) begin
         chk32("R1-random R2 R3 R4 R5 R6 R8", $urandom, $urandom, ops[k % 5]);
      end
      for (int k = 0; k < 32; k++) begin
         chk32("R7 random code", $urandom, $urandom, 4'(k % 16));
      end
   endtask

   task automatic t_narrow;
      logic [3:0] ops [5] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111};
      chk8("R5 narrow overflow", 8'h80, 8'h01, 4'b0111);
      chk8("R4 narrow min minus one", 8'h80, 8'h01, 4'b0110);
      for (int k = 0; k < 500; k++) begin
         chk8("R1 R3 R4 R5 narrow", 8'($urandom), 8'($urandom), ops[k % 5]);
      end
   endtask

   initial begin
      a32 = '0; b32 = '0; op32 = '0;
      a8 = '0; b8 = '0; op8 = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      fork
         begin
            t_idle();
            t_logic();
            t_add();
            t_sub();
            t_slt();
            t_unused();
            t_random32();
            t_narrow();
         end
         begin
            repeat (50000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule